// File: doc/BRIEF.md
# Key-Schedule Mixing Round Datapath

This block computes one mixing step of a 32-bit block-cipher key schedule. Each step takes the two running words A and B, one word from the expanded key table and one word from the secret-key array. It returns the updated pair. The new A is the three-way sum of the table word, A and B, rotated left by a fixed three places. The new B is the three-way sum of the key-array word, the new A and B. That sum is rotated left by a data-dependent amount, which comes from the low five bits of (new A + B).

The datapath has two register stages and accepts a fresh operand set every clock. A valid flag travels alongside the data. A surrounding sequencer owns the tables, the indices and the outer loop. It feeds operands in and writes results back two cycles later. A parameter replaces the table-word input with a compile-time constant for schedules where that operand is fixed.

Top module: `rc5kx_round`

## Requirements
- R1: `a_out` equals (S + `a_in` + `b_in`) mod 2^32 rotated left by 3, where S is `s_in`, or the constant `S_CONST` when `USE_CONST_S` = 1.
- R2: `b_out` equals (`l_in` + A' + `b_in`) mod 2^32 rotated left by r, where A' is the value of R1.
- R3: r is bits [4:0] of (A' + `b_in`) mod 2^32. The upper 27 bits of that sum have no effect on the rotation.
- R4: Operands presented with `in_valid` = 1 at a rising edge appear on `a_out`/`b_out` after the second following rising edge. At that point `out_valid` is 1. `out_valid` equals `in_valid` delayed by exactly two clocks.
- R5: A new operand set is accepted on every clock. Back-to-back valid inputs each produce their own correct result, in order.
- R6: While `rst_n` = 0 at a rising edge, `out_valid` is 0 after that edge (synchronous, active-low reset).
- R7: With `USE_CONST_S` = 1, the value on `s_in` has no effect on `a_out` or `b_out`.
- R8: A rotation amount of 0 passes the sum through unchanged, and an amount of 31 moves bit 0 to bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Operand set on the inputs is valid this cycle |
| a_in | input | 32 | Current A word |
| b_in | input | 32 | Current B word |
| s_in | input | 32 | Expanded-table word (ignored in constant mode) |
| l_in | input | 32 | Key-array word |
| out_valid | output | 1 | Results on the outputs are valid |
| a_out | output | 32 | Updated A word |
| b_out | output | 32 | Updated B word |

## Verification
The bench looks for carries lost in the wrap-around: an all-ones operand set overflows every adder. It also looks for the rotation amount being taken from the wrong sum or from too many bits. A searched operand set makes (A' + B) end in 31 while its upper bits are nonzero. A rotator that used the upper bits, or reached stage 16 wrongly, would scramble `b_out` there, and a zero-amount case exposes a rotator that shifts when it should not. Long valid runs with random gaps catch a misaligned or dropped valid flag. A second instance in constant mode, driven with random table words, would show any leak of `s_in` into the sum.

// File: rtl/rc5kx_pkg.sv
// Shared constants for the key-schedule mixing round.
// Assumes a power-of-two word width so the rotate amount is a clean bit field.
package rc5kx_pkg;
    localparam int WORD_W_DEF    = 32;
    localparam int FIXED_ROT_DEF = 3;
endpackage

// File: rtl/rc5kx_add3.sv
// Three-operand modular adder: y = a + b + c, wrapping at 2^W.
// Assumes no carry out is needed; pure combinational.
module rc5kx_add3 #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] y
);
    // sum of the three words, carry beyond W discarded
    assign y = a + b + c;
endmodule

// File: rtl/rc5kx_rotl_fixed.sv
// Left rotation by a constant R: wiring only, no gates.
// Assumes 0 < R < W.
module rc5kx_rotl_fixed #(
    parameter int W = 32,
    parameter int R = 3
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] y
);
    // rewire: low bits move up, top R bits wrap to the bottom
    assign y = {x[W-1-R:0], x[W-1 -: R]};
endmodule

// File: rtl/rc5kx_barrel_rotl.sv
// Logarithmic left rotator: stage k rotates by 2^k when amt[k] is set.
// Assumes W is a power of two and SHW = log2(W).
module rc5kx_barrel_rotl #(
    parameter int W   = 32,
    parameter int SHW = 5
) (
    input  logic [W-1:0]   x,
    input  logic [SHW-1:0] amt,
    output logic [W-1:0]   y
);
    logic [W-1:0] stg [0:SHW];

    assign stg[0] = x;

    for (genvar k = 0; k < SHW; k++) begin : g_lvl
        localparam int M = 1 << k;
        // conditional rotate by M positions
        assign stg[k+1] = amt[k] ? {stg[k][W-1-M:0], stg[k][W-1 -: M]} : stg[k];
    end

    assign y = stg[SHW];

    logic [2*W-1:0] dbl_ref;
    // reference rotate built from a double-width shift, for the check below
    always_comb begin
        dbl_ref = {x, x} << amt;
        a_r2_rotator_matches: assert (y == dbl_ref[2*W-1:W])
            else $error("R2: log rotator disagrees with shift reference");
    end
endmodule

// File: rtl/rc5kx_round.sv
// One mixing step of the key schedule, two register stages.
// Stage 1: A' = rotl(S + A + B, FIXED_ROT); B and L carried along.
// Stage 2: B' = rotl(L + A' + B, (A' + B)[SHW-1:0]).
// Assumes the caller handles tables and sequencing; only valid bits are reset.
module rc5kx_round
    import rc5kx_pkg::*;
#(
    parameter int              WORD_W      = WORD_W_DEF,
    parameter int              FIXED_ROT   = FIXED_ROT_DEF,
    parameter bit              USE_CONST_S = 1'b0,
    parameter logic [WORD_W-1:0] S_CONST   = 32'hB7E1_5163
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] a_in,
    input  logic [WORD_W-1:0] b_in,
    input  logic [WORD_W-1:0] s_in,
    input  logic [WORD_W-1:0] l_in,
    output logic              out_valid,
    output logic [WORD_W-1:0] a_out,
    output logic [WORD_W-1:0] b_out
);
    localparam int SHW = $clog2(WORD_W);

    logic [WORD_W-1:0] s_eff, sum1, a_new;
    logic [WORD_W-1:0] a_st1, b_st1, l_st1;
    logic              v_st1;
    logic [WORD_W-1:0] ab_sum, sum2, b_new;

    // table operand: live input or fixed constant
    assign s_eff = USE_CONST_S ? S_CONST : s_in;

    rc5kx_add3 #(.W(WORD_W)) u_add_a (.a(s_eff), .b(a_in), .c(b_in), .y(sum1));
    rc5kx_rotl_fixed #(.W(WORD_W), .R(FIXED_ROT)) u_rot_a (.x(sum1), .y(a_new));

    // stage 1 valid pipeline bit
    always_ff @(posedge clk) begin
        if (!rst_n) v_st1 <= 1'b0;
        else        v_st1 <= in_valid;
    end

    // stage 1 data capture, enabled by valid
    always_ff @(posedge clk) begin
        if (in_valid) begin
            a_st1 <= a_new;
            b_st1 <= b_in;
            l_st1 <= l_in;
        end
    end

    // rotation source: A' + B, wrapping
    assign ab_sum = a_st1 + b_st1;

    rc5kx_add3 #(.W(WORD_W)) u_add_b (.a(l_st1), .b(a_st1), .c(b_st1), .y(sum2));
    rc5kx_barrel_rotl #(.W(WORD_W), .SHW(SHW)) u_rot_b (
        .x(sum2), .amt(ab_sum[SHW-1:0]), .y(b_new));

    // stage 2 valid pipeline bit
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= v_st1;
    end

    // stage 2 data capture, enabled by valid
    always_ff @(posedge clk) begin
        if (v_st1) begin
            a_out <= a_st1;
            b_out <= b_new;
        end
    end

    a_r1_stage1_sum: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ({a_st1[FIXED_ROT-1:0], a_st1[WORD_W-1:FIXED_ROT]} ==
                      $past(s_eff + a_in + b_in)))
        else $error("R1: stage-1 A' does not unrotate to S+A+B");

    a_r4_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (out_valid == $past(in_valid, 2)))
        else $error("R4: out_valid is not in_valid delayed by two");

    a_r6_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !out_valid)
        else $error("R6: out_valid set after reset edge");

    a_r2_a_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (a_out == $past(a_st1)))
        else $error("R2: stage-2 A' not carried from stage 1");
endmodule

// File: tb/sim_rc5kx_round.sv
module sim_rc5kx_round;
    localparam int W = 32;
    localparam int N = 3000;
    localparam logic [W-1:0] KS = 32'h9E37_79B9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0, s_in = '0, l_in = '0;
    logic ov0, ov1;
    logic [W-1:0] ao0, bo0, ao1, bo1;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [W-1:0] ha [0:N-1];
    logic [W-1:0] hb [0:N-1];
    logic [W-1:0] hs [0:N-1];
    logic [W-1:0] hl [0:N-1];
    logic         hv [0:N-1];

    always #2 clk = ~clk;

    rc5kx_round u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_in(a_in), .b_in(b_in), .s_in(s_in), .l_in(l_in),
        .out_valid(ov0), .a_out(ao0), .b_out(bo0));

    rc5kx_round #(.USE_CONST_S(1'b1), .S_CONST(KS)) u1 (.clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .a_in(a_in), .b_in(b_in), .s_in(s_in), .l_in(l_in),
        .out_valid(ov1), .a_out(ao1), .b_out(bo1));

    function automatic logic [W-1:0] rotl(input logic [W-1:0] x, input int n);
        int m = n % W;
        if (m == 0) return x;
        return (x << m) | (x >> (W - m));
    endfunction

    function automatic logic [W-1:0] exp_a(input logic [W-1:0] s, a, b);
        return rotl(s + a + b, 3);
    endfunction

    function automatic logic [W-1:0] exp_b(input logic [W-1:0] s, a, b, l);
        logic [W-1:0] an = exp_a(s, a, b);
        logic [W-1:0] t  = an + b;
        return rotl(l + an + b, int'(t[4:0]));
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_slot(input int k);
        chk("R4 valid u0", W'(ov0), W'(hv[k]));
        chk("R4 valid u1", W'(ov1), W'(hv[k]));
        if (hv[k]) begin
            chk("R1 a_out", ao0, exp_a(hs[k], ha[k], hb[k]));
            chk("R2 R3 R5 b_out", bo0, exp_b(hs[k], ha[k], hb[k], hl[k]));
            chk("R7 a_out const", ao1, exp_a(KS, ha[k], hb[k]));
            chk("R7 b_out const", bo1, exp_b(KS, ha[k], hb[k], hl[k]));
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        // directed slots first, then random with gaps
        for (int k = 0; k < N; k++) begin
            hv[k] = (k < 40) ? 1'b1 : ($urandom % 4 != 0);
            ha[k] = $urandom; hb[k] = $urandom; hs[k] = $urandom; hl[k] = $urandom;
        end
        // R8 zero rotation: everything zero except L
        ha[0] = '0; hb[0] = '0; hs[0] = '0; hl[0] = 32'h8000_0001;
        // R1 wrap: all ones
        ha[1] = '1; hb[1] = '1; hs[1] = '1; hl[1] = '1;
        // R3 R8 amount 31 with high bits set: search B
        ha[2] = 32'h1234_5678; hs[2] = 32'h0BAD_F00D; hl[2] = 32'h0000_0001;
        for (int t = 0; t < 4000; t++) begin
            logic [W-1:0] an = exp_a(hs[2], ha[2], W'(t) * 32'h0101_0107);
            logic [W-1:0] sm = an + W'(t) * 32'h0101_0107;
            if (sm[4:0] == 5'd31 && sm[31:5] != '0) begin
                hb[2] = W'(t) * 32'h0101_0107;
                break;
            end
        end

        repeat (3) @(negedge clk);
        in_valid = 1'b1;
        @(negedge clk);
        chk("R6 reset valid u0", W'(ov0), '0);
        chk("R6 reset valid u1", W'(ov1), '0);
        rst_n = 1'b1;

        for (int c = 0; c < N + 2; c++) begin
            @(negedge clk);
            if (c >= 2) check_slot(c - 2);
            if (c < N) begin
                in_valid = hv[c]; a_in = ha[c]; b_in = hb[c]; s_in = hs[c]; l_in = hl[c];
            end else begin
                in_valid = 1'b0;
            end
        end
        // directed R8 at 31: bit0 of sum reaches bit31 (sum = 1+...): covered by slot 2
        in_valid = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R6 mid-run reset u0", W'(ov0), '0);
        chk("R6 mid-run reset u1", W'(ov1), '0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end
endmodule